// File: doc/BRIEF.md
# Platform Level Interrupt Controller

This block gathers level-sensitive interrupt lines from up to 31 global sources and presents them to a small number of target contexts. Each context has its own interrupt request output. Software programs the controller through a single-cycle register bus. It sets a small priority value for each source, a per-context enable mask and a per-context priority threshold.

A gateway for each source latches a raised level as pending. For each context, an arbiter picks the best pending candidate that is enabled and whose priority beats the threshold. A context's request line is high while such a candidate exists. Software reads the context's claim word to take the winning source ID. That read clears the source's pending state and holds the source off until the same ID is written back as a completion.

Top module: `pic_hub`

## Requirements
- R1: Source ID 0 does not exist. The priority word at byte offset 0 reads 0 and ignores writes, and enable bit 0 of every context reads 0 whatever is written to it.
- R2: The priority of source n is the word at byte offset 4*n. It is 3 bits wide: bits [2:0] of a write are kept, and the upper bits are dropped and read as 0.
- R3: The enable word of context c is at byte offset 0x2000 + 0x80*c. Source n is bit n%32 of word n/32 of that region, and the bit reads back as written.
- R4: The control page of context c starts at byte offset 0x200000 + 0x1000*c. The threshold is at page offset 0x0 (3 bits, read back as written), and the claim/complete word is at page offset 0x4.
- R5: A pending, enabled source qualifies for a context only when its priority is strictly greater than that context's threshold. A source with priority 0 never qualifies.
- R6: Among the qualifying sources, the one with the highest priority is selected. When priorities tie, the source with the lowest ID is selected.
- R7: A read of a claim word returns the selected source ID for that context and clears that source's pending state. When nothing qualifies, the read returns 0.
- R8: A claimed source stays out of the pending state, whatever its input level, until its own ID is written to any context's claim/complete word. After that write it can become pending again.
- R9: A completion write of 0, of an ID above the source count, or of a source that is not in service changes nothing.
- R10: Bit c of `irq_o` is high exactly when at least one source qualifies for context c. The bit is a combinational function of registered state only.
- R11: After reset, all priorities, enables, thresholds, pending and in-service states are 0, and every `irq_o` bit is low.
- R12: A source whose input is high while it is neither pending nor in service becomes pending on the next clock edge. A low input never makes a source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | NUM_SRC | Level interrupt inputs. Bit i is source ID i+1 |
| reg_addr | input | ADDR_W | Byte address of the register access. Bits [1:0] are ignored |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe. A claim read takes effect at the clock edge |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd, 0 when no read is active |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
Selection is tried in four ways: a single source below or at the threshold, a source just above it, several sources with distinct priorities, and two sources tied at the top priority. Together these separate the strict-greater rule from a greater-or-equal rule, and lowest-ID tie-breaking from highest-ID. The claim and completion handshake is tried with the source level held high throughout, so a missing hold-off shows up as an early re-claim. Completion is also tried with IDs 0, a valid ID that is not in service, and an out-of-range ID that would alias to a live source if it were truncated. Two contexts with different masks show that a claim through one context removes the source from the other.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Fixed layout of the register space (byte offsets)
  localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [11:0] OFF_THRESH = 12'h000;
  localparam logic [11:0] OFF_CLAIM  = 12'h004;
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic in_service
);
  logic pend_q, pend_d, svc_q, svc_d, upd;

  always_comb begin
    pend_d = pend_q;
    svc_d  = svc_q;
    if (claim) begin
      pend_d = 1'b0;
      svc_d  = 1'b1;
    end else begin
      if (level && !pend_q && !svc_q) pend_d = 1'b1;
      if (complete && svc_q)          svc_d  = 1'b0;
    end
    upd = (pend_d != pend_q) || (svc_d != svc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
    end
  end

  assign pending    = pend_q;
  assign in_service = svc_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC:1]             pend,
  input  logic [NUM_SRC:1]             en,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]            thr,
  output logic [ID_W-1:0]              best_id,
  output logic                         found
);
  logic [PRIO_W-1:0] best_p;

  // Walk from the highest ID down; ">=" lets a lower ID take a tie.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    found   = 1'b0;
    for (int i = NUM_SRC; i >= 1; i--) begin
      if (pend[i] && en[i] && (prio[i] > thr) && (!found || prio[i] >= best_p)) begin
        found   = 1'b1;
        best_p  = prio[i];
        best_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_hub.sv
module pic_hub #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_rd,
  output logic [31:0]        reg_rdata,
  output logic [NUM_CTX-1:0] irq_o
);
  import pic_pkg::*;

  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Address decode
  logic [31:0]      a32, en_rel, ctx_rel, prio_idx, en_word;
  logic [CTX_W-1:0] en_ctx, c_ctx;
  logic [11:0]      c_off;
  logic             is_prio, is_en, is_ctx;

  always_comb begin
    a32      = {{(32-ADDR_W){1'b0}}, reg_addr[ADDR_W-1:2], 2'b00};
    en_rel   = a32 - EN_BASE;
    ctx_rel  = a32 - CTX_BASE;
    is_prio  = (a32 < EN_BASE);
    is_en    = (a32 >= EN_BASE) && (a32 < EN_BASE + EN_STRIDE * NUM_CTX);
    is_ctx   = (a32 >= CTX_BASE) && (a32 < CTX_BASE + CTX_STRIDE * NUM_CTX);
    prio_idx = (a32 - PRIO_BASE) >> 2;
    en_word  = {25'd0, en_rel[6:2]};
    en_ctx   = CTX_W'(en_rel >> 7);
    c_ctx    = CTX_W'(ctx_rel >> 12);
    c_off    = ctx_rel[11:0];
  end

  // Configuration state
  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q, en_d;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic prio_we, en_we, thr_we;

  always_comb begin
    prio_d  = prio_q;
    en_d    = en_q;
    thr_d   = thr_q;
    prio_we = reg_wr && is_prio && (prio_idx >= 32'd1) && (prio_idx <= 32'(NUM_SRC));
    en_we   = reg_wr && is_en;
    thr_we  = reg_wr && is_ctx && (c_off == OFF_THRESH);
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (prio_idx == 32'(n)) prio_d[n] = reg_wdata[PRIO_W-1:0];
      if (en_word == 32'(n / 32)) en_d[en_ctx][n] = reg_wdata[n % 32];
    end
    thr_d[c_ctx] = reg_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      if (prio_we) prio_q <= prio_d;
      if (en_we)   en_q   <= en_d;
      if (thr_we)  thr_q  <= thr_d;
    end
  end

  // Per-context selection
  logic [NUM_SRC:1]             pend_w, insvc_w;
  logic [NUM_CTX-1:0][ID_W-1:0] best_id;
  logic [NUM_CTX-1:0]           found;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .pend(pend_w), .en(en_q[c]), .prio(prio_q), .thr(thr_q[c]),
      .best_id(best_id[c]), .found(found[c])
    );
  end
  assign irq_o = found;

  // Claim / complete handshake
  logic            claim_hit, compl_hit;
  logic [ID_W-1:0] claim_id;
  assign claim_hit = reg_rd && is_ctx && (c_off == OFF_CLAIM);
  assign claim_id  = best_id[c_ctx];
  assign compl_hit = reg_wr && is_ctx && (c_off == OFF_CLAIM) &&
                     (reg_wdata != 32'd0) && (reg_wdata <= 32'(NUM_SRC));

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    pic_gateway u_gw (
      .clk(clk), .rst_n(rst_int_n), .level(irq_src[s-1]),
      .claim(claim_hit && (claim_id == ID_W'(s))),
      .complete(compl_hit && (reg_wdata == 32'(s))),
      .pending(pend_w[s]), .in_service(insvc_w[s])
    );
  end

  // Read path
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (is_prio) begin
        for (int n = 1; n <= NUM_SRC; n++)
          if (prio_idx == 32'(n)) reg_rdata[PRIO_W-1:0] = prio_q[n];
      end else if (is_en) begin
        for (int n = 1; n <= NUM_SRC; n++)
          if (en_word == 32'(n / 32)) reg_rdata[n % 32] = en_q[en_ctx][n];
      end else if (is_ctx) begin
        if (c_off == OFF_THRESH)     reg_rdata[PRIO_W-1:0] = thr_q[c_ctx];
        else if (c_off == OFF_CLAIM) reg_rdata[ID_W-1:0]   = claim_id;
      end
    end
  end
endmodule

// File: rtl/pic_hub_chk.sv
module pic_hub_chk #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_src,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_rd,
  input logic [31:0]        reg_rdata,
  input logic [NUM_CTX-1:0] irq_o,
  input logic [NUM_SRC:1]   pend,
  input logic [NUM_SRC:1]   insvc
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [31:0] a32;
  logic        claim_rd;
  assign a32      = 32'(reg_addr);
  assign claim_rd = reg_rd && (a32 >= 32'h0020_0000) &&
                    (a32 < 32'h0020_0000 + 32'h1000 * NUM_CTX) && (reg_addr[11:0] == 12'h004);

  AST_SRC0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (a32 == 32'd0)) |-> (reg_rdata == 32'd0)); // R1

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> (pend != '0)); // R5

  AST_NO_PEND_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & insvc) == '0)); // R8

  AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && (reg_rdata != 32'd0)) |=>
      (!pend[$past(reg_rdata[ID_W-1:0])] && insvc[$past(reg_rdata[ID_W-1:0])])); // R7

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_lvl
    AST_LEVEL_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src[s-1] && !pend[s] && !insvc[s]) |=> pend[s]); // R12
  end
endmodule

bind pic_hub pic_hub_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .irq_src(irq_src), .reg_addr(reg_addr),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_o(irq_o),
  .pend(pend_w), .insvc(insvc_w)
);

// File: tb/tb_pic_hub.sv
`timescale 1ns/1ps
module tb_pic_hub;
  localparam int NS = 31;
  localparam int NC = 2;
  localparam int AW = 26;
  localparam logic [31:0] CLM0 = 32'h0020_0004, CLM1 = 32'h0020_1004;
  localparam logic [31:0] THR0 = 32'h0020_0000, THR1 = 32'h0020_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_src = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] irq_o;

  pic_hub #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  // Monitor: pops the expected item for every active read
  always @(negedge clk) begin
    if (reg_rd) begin
      item_t it;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty: actual=%0h expected=none", reg_rdata);
      end else begin
        it = sb.pop_front();
        if (reg_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%0h expected=%0h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a[AW-1:0]; reg_rd = 1'b1;
    sb.push_back('{e, tag});
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a[AW-1:0]; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic src(input int id, input logic v);
    @(posedge clk); #1;
    irq_src[id-1] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string tag);
    @(negedge clk);
    total++;
    if (irq_o !== e) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    // R11 reset state
    chk_irq(2'b00, "R11 irq after reset");
    rd(32'h4, 0, "R11 prio after reset");
    rd(32'h2000, 0, "R11 enable after reset");
    rd(THR0, 0, "R11 threshold after reset");
    rd(CLM0, 0, "R11/R7 empty claim");
    // R1 source 0
    wr(32'h0, 7);
    rd(32'h0, 0, "R1 prio of source 0");
    // R2 priority width and placement
    wr(32'hC, 32'hF);
    rd(32'hC, 7, "R2 upper prio bits dropped");
    wr(32'h14, 5);
    rd(32'h14, 5, "R2 prio source 5");
    // R3 enables, bit0 forced to 0 (R1)
    wr(32'h2000, 32'hA9);
    rd(32'h2000, 32'hA8, "R3/R1 ctx0 enable word");
    wr(32'h2080, 32'h20);
    rd(32'h2080, 32'h20, "R3 ctx1 enable word");
    // R5 priority 0 never qualifies
    src(7, 1'b1);
    idle(2);
    chk_irq(2'b00, "R5 prio 0 source");
    wr(32'h1C, 2);
    wr(THR0, 2);
    idle(1);
    chk_irq(2'b00, "R5 prio equal to threshold");
    wr(THR0, 1);
    idle(1);
    chk_irq(2'b01, "R5/R10 prio above threshold");
    // R6 ordering by priority
    src(3, 1'b1);
    src(5, 1'b1);
    idle(2);
    chk_irq(2'b11, "R12/R10 ctx1 sees source 5");
    rd(CLM0, 3, "R6 highest prio first");
    rd(CLM0, 5, "R6 second prio");
    chk_irq(2'b01, "R7 claim via ctx0 removes source from ctx1");
    rd(CLM0, 7, "R6 lowest prio last");
    rd(CLM0, 0, "R8 held sources not re-claimed");
    chk_irq(2'b00, "R8 no irq while in service");
    // R9 ignored completions
    wr(CLM0, 0);
    wr(CLM0, 9);
    wr(CLM0, 31);
    wr(CLM0, 35);
    idle(2);
    rd(CLM0, 0, "R9 bad completions ignored");
    chk_irq(2'b00, "R9 irq stays low");
    // R8 proper completion re-arms
    wr(CLM0, 3);
    idle(1);
    rd(CLM0, 3, "R8 source 3 re-armed");
    // R6 tie at top priority
    wr(32'h14, 7);
    wr(CLM1, 5);
    wr(CLM0, 3);
    idle(2);
    chk_irq(2'b11, "R6 both contexts requesting");
    rd(CLM0, 3, "R6 tie goes to lowest ID");
    rd(CLM1, 5, "R4/R6 claim through ctx1");
    rd(CLM0, 0, "R8 source 7 still in service");
    chk_irq(2'b00, "R10 nothing qualifies");
    // R12 low levels do not pend
    src(3, 1'b0);
    src(5, 1'b0);
    src(7, 1'b0);
    wr(CLM0, 3);
    wr(CLM0, 5);
    wr(CLM1, 7);
    idle(3);
    rd(CLM0, 0, "R12 low level stays idle");
    chk_irq(2'b00, "R12 irq low with low inputs");
    rd(THR0, 1, "R4 ctx0 threshold");
    rd(THR1, 0, "R4 ctx1 threshold");
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule